// File: doc/BRIEF.md
# Rotor Cipher Command Sequencer

This block is the command front end of a three-slot rotor cipher. Each clock it samples one input byte. The top three bits select an operation and the low five bits carry a letter code or setting (0 to 25 for A to Z). The sequencer turns each accepted operation into a one-cycle write strobe for the rotor datapath or the substitution table. For a scramble operation it hands the letter to the datapath and waits for the datapath's answer.

Operations have different latencies. The `ready` output is high only while a new byte can be taken, and bytes that arrive while it is low have no effect. The three per-slot setting operations each keep their own slot pointer. Repeating an operation therefore fills the right, middle and left slots in turn. The last scramble result is held on a 5-bit bus and is also shown as a letter glyph on a 7-segment output.

Top module: `cipher_cmd_seq`

## Requirements
- R1: While `rst_n` is low, and after it is released, `ready` is 1, `result` is 0, `seg` is 0, and no strobe (`start_we`, `ring_we`, `rotor_we`, `plug_we`, `scr_req`, `clr`) is high.
- R2: When `ready` is 1 and `cmd_in[7:5]` is 001 (start position), the cycle after the sampling edge has `start_we`=1, `wr_data`=`cmd_in[4:0]` and `ready`=0. The cycle after that has `ready`=1 again.
- R3: Each of the three slot operations (001 start, 010 ring, 111 rotor type) has its own slot pointer. The pointer steps 0, 1, 2 and then wraps to 0. `slot` shows the pointer value for the strobe being issued, and using one operation never moves another operation's pointer.
- R4: Code 010 (ring setting) behaves like R2 but raises `ring_we`.
- R5: Code 111 (rotor type) behaves like R2 but raises `rotor_we`.
- R6: Code 101 stores `cmd_in[4:0]` as the table address and raises no strobe, with `ready` low for one cycle. Code 110 raises `plug_we` for one cycle with `plug_addr` equal to the last stored address and `wr_data` equal to its data field.
- R7: Code 100 (scramble) raises `scr_req` for one cycle after the sampling edge, with `wr_data` set to the letter. `ready` then stays low until an edge at which `scr_done` is 1. After that edge, `ready` is 1 and `result` equals the `scr_res` sampled at that edge. `result` does not change while `ready` is held.
- R8: Bytes presented while `ready` is 0 are ignored: no strobe results from them and no slot pointer moves.
- R9: Code 000 (no operation) raises no strobe and keeps `ready` at 1.
- R10: Code 011 (reset) raises `clr` for one cycle. It returns all slot pointers and the stored table address to 0, sets `result` to 0 and blanks `seg`, and `ready` returns after one cycle.
- R11: After a scramble, `seg[6:0]` (a on bit 0 through g on bit 6) shows the glyph of `result` and `seg[7]` is 0. The glyphs are A=77h b=7Ch C=39h d=5Eh E=79h F=71h G=3Dh H=76h I=30h J=1Eh K=75h L=38h M=37h n=54h o=5Ch P=73h q=67h r=50h S=6Dh t=78h U=3Eh v=1Ch W=2Ah X=52h y=6Eh Z=5Bh. A result code above 25 gives `seg`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_in | input | 8 | Operation code [7:5] and data field [4:0] |
| scr_done | input | 1 | Datapath signals that the scramble answer is valid |
| scr_res | input | 5 | Scrambled letter from the datapath |
| ready | output | 1 | High when a new byte can be accepted |
| result | output | 5 | Last scrambled letter |
| seg | output | 8 | 7-segment glyph of the result; bit 7 is 0 |
| start_we | output | 1 | Start-position write strobe |
| ring_we | output | 1 | Ring-setting write strobe |
| rotor_we | output | 1 | Rotor-type write strobe |
| slot | output | 2 | Target slot for the slot write strobes |
| wr_data | output | 5 | Data for the write strobes and the scramble letter |
| plug_we | output | 1 | Substitution-table write strobe |
| plug_addr | output | 5 | Substitution-table address |
| scr_req | output | 1 | Scramble request to the datapath |
| clr | output | 1 | Return-to-initial-state strobe to the datapath |

## Verification
The hardest case to reach is a byte that lands while a scramble is waiting for the datapath. This takes an answer that arrives several cycles late, with a slot operation presented during that wait. The bench plays the datapath itself and holds `scr_done` back for a chosen number of cycles. During that wait it presents a start-position byte. It then checks that no strobe appeared and that the next start-position load still goes to the slot its own count predicts. Pointer wrap and pointer independence are covered by interleaving the three slot operations in the command table, and the table also runs across a reset operation.

// File: rtl/cseq_pkg.sv
package cseq_pkg;

  typedef enum logic [2:0] {
    OP_NOP      = 3'd0,
    OP_START    = 3'd1,
    OP_RING     = 3'd2,
    OP_RESET    = 3'd3,
    OP_SCRAMBLE = 3'd4,
    OP_PADDR    = 3'd5,
    OP_PDATA    = 3'd6,
    OP_ROTOR    = 3'd7
  } op_e;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_WRITE = 2'd1,
    ST_REQ   = 2'd2,
    ST_WAIT  = 2'd3
  } st_e;

  // operation served by slot pointer i (right-to-left slot operations)
  function automatic op_e slot_op(input int i);
    case (i)
      0:       return OP_START;
      1:       return OP_RING;
      default: return OP_ROTOR;
    endcase
  endfunction

  // next pointer value with wrap after the last slot
  function automatic logic [1:0] slot_step(input logic [1:0] cur, input int slots);
    if (int'(cur) >= slots - 1) return 2'd0;
    return cur + 2'd1;
  endfunction

  // segment pattern, bit0 = a ... bit6 = g
  function automatic logic [6:0] letter_glyph(input logic [4:0] code);
    case (code)
      5'd0:  return 7'h77;
      5'd1:  return 7'h7C;
      5'd2:  return 7'h39;
      5'd3:  return 7'h5E;
      5'd4:  return 7'h79;
      5'd5:  return 7'h71;
      5'd6:  return 7'h3D;
      5'd7:  return 7'h76;
      5'd8:  return 7'h30;
      5'd9:  return 7'h1E;
      5'd10: return 7'h75;
      5'd11: return 7'h38;
      5'd12: return 7'h37;
      5'd13: return 7'h54;
      5'd14: return 7'h5C;
      5'd15: return 7'h73;
      5'd16: return 7'h67;
      5'd17: return 7'h50;
      5'd18: return 7'h6D;
      5'd19: return 7'h78;
      5'd20: return 7'h3E;
      5'd21: return 7'h1C;
      5'd22: return 7'h2A;
      5'd23: return 7'h52;
      5'd24: return 7'h6E;
      5'd25: return 7'h5B;
      default: return 7'h00;
    endcase
  endfunction

endpackage

// File: rtl/cseq_slot_ctr.sv
module cseq_slot_ctr #(
  parameter int SLOTS  = 3,
  parameter int SLOT_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              adv,
  output logic [SLOT_W-1:0] ptr
);
  import cseq_pkg::*;

  logic [1:0] step_w;
  assign step_w = slot_step(2'(ptr), SLOTS);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   ptr <= '0;
    else if (clr) ptr <= '0;
    else if (adv) ptr <= SLOT_W'(step_w);
  end
endmodule

// File: rtl/cseq_seg_drv.sv
module cseq_seg_drv #(
  parameter int DAT_W = 5,
  parameter int SEG_W = 8
) (
  input  logic             show,
  input  logic [DAT_W-1:0] code,
  output logic [SEG_W-1:0] seg
);
  import cseq_pkg::*;

  always_comb begin
    seg = '0;
    if (show) seg[6:0] = letter_glyph(5'(code));
  end
endmodule

// File: rtl/cipher_cmd_seq.sv
module cipher_cmd_seq #(
  parameter int CMD_W = 3,
  parameter int DAT_W = 5,
  parameter int SLOTS = 3,
  parameter int SEG_W = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [CMD_W+DAT_W-1:0]   cmd_in,
  input  logic                     scr_done,
  input  logic [DAT_W-1:0]         scr_res,
  output logic                     ready,
  output logic [DAT_W-1:0]         result,
  output logic [SEG_W-1:0]         seg,
  output logic                     start_we,
  output logic                     ring_we,
  output logic                     rotor_we,
  output logic [$clog2(SLOTS)-1:0] slot,
  output logic [DAT_W-1:0]         wr_data,
  output logic                     plug_we,
  output logic [DAT_W-1:0]         plug_addr,
  output logic                     scr_req,
  output logic                     clr
);
  import cseq_pkg::*;

  localparam int IN_W    = CMD_W + DAT_W;
  localparam int SLOT_W  = $clog2(SLOTS);
  localparam int N_PTRS  = 3;

  st_e              state;
  op_e              op_q;
  logic [DAT_W-1:0] dat_q;
  logic [DAT_W-1:0] paddr_q;
  logic [DAT_W-1:0] res_q;
  logic             res_vld;

  op_e              op_in;
  logic             accept;
  logic             wr_fire;
  logic             done_fire;
  logic             ptr_clr;
  logic [N_PTRS-1:0] ptr_adv;
  logic [SLOT_W-1:0] ptr_val [N_PTRS];

  assign op_in     = op_e'(cmd_in[IN_W-1:DAT_W]);
  assign ready     = (state == ST_IDLE);
  assign accept    = ready && (op_in != OP_NOP);
  assign wr_fire   = (state == ST_WRITE);
  assign done_fire = (state == ST_WAIT) && scr_done;
  assign ptr_clr   = wr_fire && (op_q == OP_RESET);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      op_q  <= OP_NOP;
      dat_q <= '0;
    end else begin
      case (state)
        ST_IDLE: if (accept) begin
          op_q  <= op_in;
          dat_q <= cmd_in[DAT_W-1:0];
          state <= (op_in == OP_SCRAMBLE) ? ST_REQ : ST_WRITE;
        end
        ST_WRITE: state <= ST_IDLE;
        ST_REQ:   state <= ST_WAIT;
        ST_WAIT:  if (scr_done) state <= ST_IDLE;
        default:  state <= ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      paddr_q <= '0;
      res_q   <= '0;
      res_vld <= 1'b0;
    end else if (ptr_clr) begin
      paddr_q <= '0;
      res_q   <= '0;
      res_vld <= 1'b0;
    end else begin
      if (wr_fire && op_q == OP_PADDR) paddr_q <= dat_q;
      if (done_fire) begin
        res_q   <= scr_res;
        res_vld <= 1'b1;
      end
    end
  end

  for (genvar i = 0; i < N_PTRS; i++) begin : g_ptr
    assign ptr_adv[i] = wr_fire && (op_q == slot_op(i));
    cseq_slot_ctr #(.SLOTS(SLOTS), .SLOT_W(SLOT_W)) u_ctr (
      .clk  (clk),
      .rst_n(rst_n),
      .clr  (ptr_clr),
      .adv  (ptr_adv[i]),
      .ptr  (ptr_val[i])
    );
  end

  always_comb begin
    slot = '0;
    for (int i = 0; i < N_PTRS; i++)
      if (op_q == slot_op(i)) slot = ptr_val[i];
  end

  assign start_we  = ptr_adv[0];
  assign ring_we   = ptr_adv[1];
  assign rotor_we  = ptr_adv[2];
  assign plug_we   = wr_fire && (op_q == OP_PDATA);
  assign clr       = ptr_clr;
  assign scr_req   = (state == ST_REQ);
  assign wr_data   = dat_q;
  assign plug_addr = paddr_q;
  assign result    = res_q;

  cseq_seg_drv #(.DAT_W(DAT_W), .SEG_W(SEG_W)) u_seg (
    .show(res_vld),
    .code(res_q),
    .seg (seg)
  );
endmodule

// File: rtl/cipher_cmd_seq_chk.sv
module cipher_cmd_seq_chk #(
  parameter int SLOTS = 3
) (
  input logic       clk,
  input logic       rst_n,
  input logic [7:0] cmd_in,
  input logic       ready,
  input logic [4:0] result,
  input logic       start_we,
  input logic       ring_we,
  input logic       rotor_we,
  input logic       plug_we,
  input logic       scr_req,
  input logic       clr,
  input logic [1:0] slot
);
  logic any_wr;
  assign any_wr = start_we | ring_we | rotor_we | plug_we | clr;

  AST_STROBE_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({start_we, ring_we, rotor_we, plug_we, scr_req, clr})); // R2
  AST_BUSY_ON_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    (any_wr | scr_req) |-> !ready); // R8
  AST_WRITE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    any_wr |=> ready); // R2
  AST_SLOT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (start_we | ring_we | rotor_we) |-> (int'(slot) < SLOTS)); // R3
  AST_SCR_WAITS: assert property (@(posedge clk) disable iff (!rst_n)
    scr_req |=> !ready); // R7
  AST_RESULT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (ready && $past(ready)) |-> $stable(result)); // R7
  AST_NOP_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (ready && cmd_in[7:5] == 3'b000) |=> ready); // R9
  AST_CLR_RETURNS: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (ready && result == 5'd0)); // R10
endmodule

bind cipher_cmd_seq cipher_cmd_seq_chk #(.SLOTS(SLOTS)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .cmd_in  (cmd_in),
  .ready   (ready),
  .result  (result),
  .start_we(start_we),
  .ring_we (ring_we),
  .rotor_we(rotor_we),
  .plug_we (plug_we),
  .scr_req (scr_req),
  .clr     (clr),
  .slot    (slot)
);

// File: tb/sim_cipher_cmd_seq.sv
module sim_cipher_cmd_seq;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] cmd_in = 8'h00;
  logic       scr_done = 1'b0;
  logic [4:0] scr_res = 5'd0;
  logic       ready, start_we, ring_we, rotor_we, plug_we, scr_req, clr;
  logic [4:0] result, wr_data, plug_addr;
  logic [7:0] seg;
  logic [1:0] slot;

  int n_chk = 0;
  int n_err = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  cipher_cmd_seq u0 (
    .clk(clk), .rst_n(rst_n), .cmd_in(cmd_in), .scr_done(scr_done),
    .scr_res(scr_res), .ready(ready), .result(result), .seg(seg),
    .start_we(start_we), .ring_we(ring_we), .rotor_we(rotor_we),
    .slot(slot), .wr_data(wr_data), .plug_we(plug_we),
    .plug_addr(plug_addr), .scr_req(scr_req), .clr(clr)
  );

  logic [5:0] stb;
  assign stb = {scr_req, clr, plug_we, rotor_we, ring_we, start_we};

  // glyphs written as the bench's own list, index = letter code
  localparam logic [6:0] GLYPHS [26] = '{
    7'h77, 7'h7C, 7'h39, 7'h5E, 7'h79, 7'h71, 7'h3D, 7'h76, 7'h30, 7'h1E,
    7'h75, 7'h38, 7'h37, 7'h54, 7'h5C, 7'h73, 7'h67, 7'h50, 7'h6D, 7'h78,
    7'h3E, 7'h1C, 7'h2A, 7'h52, 7'h6E, 7'h5B };

  // {op[2:0], data[4:0], strobe id[2:0], slot[1:0], table addr[4:0]}
  // strobe id: 0 none, 1 start, 2 ring, 3 rotor, 4 table, 5 clr
  localparam int NV = 23;
  localparam logic [17:0] VEC [NV] = '{
    {3'b001, 5'd15, 3'd1, 2'd0, 5'd0},
    {3'b001, 5'd5,  3'd1, 2'd1, 5'd0},
    {3'b010, 5'd18, 3'd2, 2'd0, 5'd0},
    {3'b001, 5'd1,  3'd1, 2'd2, 5'd0},
    {3'b001, 5'd7,  3'd1, 2'd0, 5'd0},
    {3'b111, 5'd4,  3'd3, 2'd0, 5'd0},
    {3'b111, 5'd1,  3'd3, 2'd1, 5'd0},
    {3'b010, 5'd5,  3'd2, 2'd1, 5'd0},
    {3'b010, 5'd24, 3'd2, 2'd2, 5'd0},
    {3'b010, 5'd3,  3'd2, 2'd0, 5'd0},
    {3'b111, 5'd2,  3'd3, 2'd2, 5'd0},
    {3'b111, 5'd0,  3'd3, 2'd0, 5'd0},
    {3'b101, 5'd0,  3'd0, 2'd0, 5'd0},
    {3'b110, 5'd13, 3'd4, 2'd0, 5'd0},
    {3'b101, 5'd25, 3'd0, 2'd0, 5'd0},
    {3'b110, 5'd1,  3'd4, 2'd0, 5'd25},
    {3'b110, 5'd2,  3'd4, 2'd0, 5'd25},
    {3'b000, 5'd9,  3'd0, 2'd0, 5'd0},
    {3'b011, 5'd0,  3'd5, 2'd0, 5'd0},
    {3'b110, 5'd6,  3'd4, 2'd0, 5'd0},
    {3'b001, 5'd9,  3'd1, 2'd0, 5'd0},
    {3'b010, 5'd9,  3'd2, 2'd0, 5'd0},
    {3'b111, 5'd3,  3'd3, 2'd0, 5'd0}
  };

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // scramble with the bench acting as datapath; dly cycles before the answer
  task automatic scramble(input logic [4:0] ch, input int dly, input logic [4:0] rv);
    cmd_in = {3'b100, ch};
    @(posedge clk); #1;
    chk(stb == 6'b100000 && wr_data == ch, "R7 request", {stb, 3'b0, wr_data}, {6'b100000, 3'b0, ch});
    chk(ready == 1'b0, "R7 busy", ready, 0);
    cmd_in = 8'h00;
    @(posedge clk); #1;
    for (int k = 0; k < dly; k++) begin
      if (k == 0) cmd_in = {3'b001, 5'd3};
      @(posedge clk); #1;
      chk(ready == 1'b0 && stb == 6'b0, "R8 ignored while busy", {ready, stb}, 0);
      cmd_in = 8'h00;
    end
    scr_done = 1'b1;
    scr_res  = rv;
    @(posedge clk); #1;
    scr_done = 1'b0;
    chk(ready == 1'b1 && result == rv, "R7 result", {ready, 3'b0, result}, {1'b1, 3'b0, rv});
    chk(seg == ((rv < 26) ? {1'b0, GLYPHS[rv]} : 8'h00), "R11 glyph", seg,
        (rv < 26) ? {1'b0, GLYPHS[rv]} : 8'h00);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    chk(ready == 1'b1 && result == 5'd0 && seg == 8'h00 && stb == 6'b0,
        "R1 reset state", {ready, result, seg, stb}, {1'b1, 5'd0, 8'h00, 6'b0});
    rst_n = 1'b1;
    @(posedge clk); #1;
    chk(ready == 1'b1 && stb == 6'b0, "R1 after release", {ready, stb}, {1'b1, 6'b0});

    // command table: R2 R3 R4 R5 R6 R9 R10
    for (int v = 0; v < NV; v++) begin
      logic [2:0] op;
      logic [4:0] dat;
      logic [2:0] id;
      logic [1:0] es;
      logic [4:0] ea;
      logic [5:0] exp_stb;
      {op, dat, id, es, ea} = VEC[v];
      exp_stb = (id == 3'd0) ? 6'b0 : 6'(1 << (id - 1));
      cmd_in = {op, dat};
      @(posedge clk); #1;
      cmd_in = 8'h00;
      chk(stb == exp_stb, $sformatf("R2 R4 R5 R6 R9 R10 strobe v%0d", v), stb, exp_stb);
      chk(ready == (op == 3'b000), $sformatf("R2 R9 ready after accept v%0d", v), ready, op == 3'b000);
      if (id >= 3'd1 && id <= 3'd3)
        chk(slot == es, $sformatf("R3 slot v%0d", v), slot, es);
      if (id >= 3'd1 && id <= 3'd4)
        chk(wr_data == dat, $sformatf("R2 data v%0d", v), wr_data, dat);
      if (id == 3'd4)
        chk(plug_addr == ea, $sformatf("R6 table addr v%0d", v), plug_addr, ea);
      @(posedge clk); #1;
      chk(ready == 1'b1 && stb == 6'b0, $sformatf("R2 ready back v%0d", v), {ready, stb}, {1'b1, 6'b0});
    end

    // scrambles with assorted answer delays
    scramble(5'd11, 0, 5'd23);
    scramble(5'd14, 4, 5'd10);
    for (int c = 0; c < 26; c++) scramble(5'(c), c % 3, 5'(25 - c));
    scramble(5'd2, 1, 5'd27);

    // R8: start pointer was 1 before the ignored byte; next start goes to slot 1
    cmd_in = {3'b001, 5'd20};
    @(posedge clk); #1;
    cmd_in = 8'h00;
    chk(start_we == 1'b1 && slot == 2'd1, "R8 pointer unmoved", {start_we, slot}, {1'b1, 2'd1});
    @(posedge clk); #1;

    // R10: reset operation after a visible result
    scramble(5'd0, 2, 5'd4);
    cmd_in = {3'b011, 5'd17};
    @(posedge clk); #1;
    cmd_in = 8'h00;
    chk(clr == 1'b1, "R10 clear strobe", clr, 1);
    @(posedge clk); #1;
    chk(ready == 1'b1 && result == 5'd0 && seg == 8'h00, "R10 result blanked",
        {ready, result, seg}, {1'b1, 5'd0, 8'h00});
    cmd_in = {3'b111, 5'd1};
    @(posedge clk); #1;
    cmd_in = 8'h00;
    chk(rotor_we == 1'b1 && slot == 2'd0, "R10 R3 pointer cleared", {rotor_we, slot}, {1'b1, 2'd0});
    @(posedge clk); #1;

    // R9: a run of no-operation bytes keeps everything idle
    cmd_in = 8'h1F;
    repeat (3) begin
      @(posedge clk); #1;
      chk(ready == 1'b1 && stb == 6'b0 && result == 5'd0, "R9 idle", {ready, stb}, {1'b1, 6'b0});
    end
    cmd_in = 8'h00;

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end
endmodule